// File: doc/BRIEF.md
# Slave-Mode Audio Clock Ratio Monitor

This block runs on the master clock of an audio converter that receives its frame clock (LRCK) and bit clock (SCLK) from outside. It measures how many master-clock cycles and how many bit-clock rising edges fall into each frame. From the frame measurement and the selected speed mode it derives the master-clock prescale. After prescaling, the converter core sees 256 master clocks per frame in single speed, 128 in double speed and 64 in quad speed. The bit-clock count is checked against the set of values the current mode allows.

Both frame and bit clocks are sampled through synchronizer chains and turned into single-cycle rising-edge pulses. A period meter captures both counts at each frame-clock rising edge. A combinational judge decides legality and the prescale code. A small tracker then asserts lock once two consecutive frames agree. It drops lock and raises the error flag when a measurement is illegal or differs from the previous one. The prescale output keeps its last locked value while the block is unlocked. The block generates no clocks.

Top module: `slv_clk_ratio_mon`

## Requirements
- R1: While reset is low and directly after it, lock_o=0, err_o=0, prescale_o=000 and ratio_o=0.
- R2: ratio_o gives the number of master-clock cycles between the last two LRCK rising edges. It is valid by the fourth rising master-clock edge after the LRCK rise is presented at the input.
- R3: Prescale encoding is 000=÷1, 001=÷1.5, 010=÷2, 011=÷3, 100=÷4. In single speed (speed_i=00), frame ratios 256, 384, 512, 768 and 1024 select these codes in that order.
- R4: In double speed (speed_i=01), frame ratios 128, 192, 256, 384 and 512 select codes 000 to 100 in that order.
- R5: In quad speed (speed_i=10), frame ratios 64, 96, 128, 192 and 256 select codes 000 to 100 in that order.
- R6: Bit-clock counts of 32, 48 and 64 per frame are legal in every speed mode, and 128 is legal only in single speed. speed_i=11 makes every measurement illegal.
- R7: lock_o rises only when a legal measurement equals the previous legal measurement in frame ratio, bit-clock count and speed mode. A legal measurement that is the first after reset, after an illegal one or after a timeout clears err_o and leaves lock_o at 0.
- R8: An illegal measurement clears lock_o and sets err_o.
- R9: A legal measurement that differs from the previous legal one, in ratios or in speed mode, clears lock_o and sets err_o. The new values lock after one repeat.
- R10: prescale_o changes only on cycles where lock_o is 1, and keeps its last locked code while unlocked.
- R11: If no LRCK rising edge arrives for 4095 master-clock cycles, ratio_o becomes 4095, lock_o clears and err_o sets. The next LRCK rising edge only starts a new measurement.
- R12: lock_o and err_o are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock; all logic runs on its rising edge |
| rst_ni | input | 1 | Active-low reset |
| lrck_i | input | 1 | Frame clock from the external clock master |
| sclk_i | input | 1 | Bit clock from the external clock master |
| speed_i | input | 2 | Speed mode: 00 single, 01 double, 10 quad, 11 reserved |
| prescale_o | output | 3 | Selected master-clock prescale code |
| ratio_o | output | CNT_W | Last measured master clocks per frame |
| lock_o | output | 1 | Ratios stable and legal |
| err_o | output | 1 | Last measurement illegal, changed or timed out |

## Verification
A corrupted frame or bit counter shows up at ratio_o, and usually at lock_o and err_o, within four master-clock cycles of the next LRCK rise. A miscomputed table entry in the judge shows a wrong prescale_o or a spurious err_o on the second frame of a run at that ratio. A stale previous-measurement register shows as lock that comes one frame too early or too late, or as a missing error after a ratio or mode change. The scoreboard compares all four outputs after every frame, across all three speed modes, all five prescales, illegal bit clocks, the reserved mode and a frame-clock timeout.

// File: rtl/scr_pkg.sv
package scr_pkg;

    typedef enum logic [1:0] {
        SPD_SINGLE = 2'b00,
        SPD_DOUBLE = 2'b01,
        SPD_QUAD   = 2'b10,
        SPD_RSVD   = 2'b11
    } speed_e;

    typedef enum logic [2:0] {
        PSC_DIV1   = 3'b000,
        PSC_DIV1P5 = 3'b001,
        PSC_DIV2   = 3'b010,
        PSC_DIV3   = 3'b011,
        PSC_DIV4   = 3'b100
    } psc_e;

    // number of prescale choices and of legal bit-clock counts
    localparam int unsigned NUM_PSC = 5;
    localparam int unsigned NUM_BIT = 4;

endpackage

// File: rtl/scr_edge_sync.sv
// Synchronizer chain followed by a rising-edge detector.
module scr_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic rise_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              last;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], async_i};
        st_d.last  = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise_o = st_q.chain[STAGES-1] & ~st_q.last;

endmodule

// File: rtl/scr_period_meter.sv
// Counts master clocks and bit-clock edges per frame; also flags a missing frame clock.
module scr_period_meter #(
    parameter int unsigned CNT_W  = 12,
    parameter int unsigned SCNT_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              frame_rise_i,
    input  logic              bit_rise_i,
    output logic              meas_valid_o,
    output logic [CNT_W-1:0]  mclk_cnt_o,
    output logic [SCNT_W-1:0] bit_cnt_o
);

    localparam logic [CNT_W-1:0]  CYC_MAX  = '1;
    localparam logic [CNT_W-1:0]  CYC_LAST = CYC_MAX - 1'b1;
    localparam logic [SCNT_W-1:0] BIT_MAX  = '1;

    typedef struct packed {
        logic              started;
        logic [CNT_W-1:0]  cyc;
        logic [SCNT_W-1:0] bits;
        logic              valid;
        logic [CNT_W-1:0]  m_cap;
        logic [SCNT_W-1:0] b_cap;
    } meter_st_t;

    meter_st_t st_d, st_q;
    logic [CNT_W-1:0]  cyc_next;
    logic [SCNT_W-1:0] bits_next;

    always_comb begin
        cyc_next  = (st_q.cyc == CYC_MAX) ? st_q.cyc : st_q.cyc + 1'b1;
        bits_next = st_q.bits;
        if (bit_rise_i && st_q.bits != BIT_MAX) begin
            bits_next = st_q.bits + 1'b1;
        end

        st_d       = st_q;
        st_d.valid = 1'b0;

        if (frame_rise_i) begin
            if (st_q.started) begin
                st_d.valid = 1'b1;
                st_d.m_cap = cyc_next;
                st_d.b_cap = bits_next;
            end
            st_d.started = 1'b1;
            st_d.cyc     = '0;
            st_d.bits    = '0;
        end else begin
            st_d.cyc  = cyc_next;
            st_d.bits = bits_next;
            if (st_q.started && st_q.cyc == CYC_LAST) begin
                // frame clock missing: report a saturated, illegal period
                st_d.valid   = 1'b1;
                st_d.m_cap   = CYC_MAX;
                st_d.b_cap   = bits_next;
                st_d.started = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign meas_valid_o = st_q.valid;
    assign mclk_cnt_o   = st_q.m_cap;
    assign bit_cnt_o    = st_q.b_cap;

endmodule

// File: rtl/scr_ratio_judge.sv
// Combinational legality check and prescale selection.
module scr_ratio_judge
    import scr_pkg::*;
#(
    parameter int unsigned CNT_W      = 12,
    parameter int unsigned SCNT_W     = 8,
    parameter int unsigned BASE_RATIO = 256,
    parameter int unsigned BIT_UNIT   = 32
) (
    input  logic [1:0]        speed_i,
    input  logic [CNT_W-1:0]  mclk_cnt_i,
    input  logic [SCNT_W-1:0] bit_cnt_i,
    output logic              legal_o,
    output logic [2:0]        code_o
);

    localparam int unsigned TW = CNT_W + 4;
    localparam int unsigned BW = SCNT_W + 4;

    // prescale factors in half steps: 1, 1.5, 2, 3, 4
    function automatic logic [3:0] psc_half(input int unsigned k);
        case (k)
            0:       psc_half = 4'd2;
            1:       psc_half = 4'd3;
            2:       psc_half = 4'd4;
            3:       psc_half = 4'd6;
            default: psc_half = 4'd8;
        endcase
    endfunction

    // bit-clock multiples of BIT_UNIT in half steps: 1, 1.5, 2, 4
    function automatic logic [3:0] bit_half(input int unsigned k);
        case (k)
            0:       bit_half = 4'd2;
            1:       bit_half = 4'd3;
            2:       bit_half = 4'd4;
            default: bit_half = 4'd8;
        endcase
    endfunction

    logic [TW-1:0]      unit;
    logic [NUM_PSC-1:0] m_hit;
    logic [NUM_BIT-1:0] b_hit;
    logic               spd_ok;

    assign unit   = TW'(BASE_RATIO) >> speed_i;
    assign spd_ok = (speed_i != SPD_RSVD);

    for (genvar k = 0; k < NUM_PSC; k++) begin : g_psc
        logic [TW-1:0] tgt;
        assign tgt      = (unit * TW'(psc_half(k))) >> 1;
        assign m_hit[k] = ({4'b0000, mclk_cnt_i} == tgt);
    end

    for (genvar k = 0; k < NUM_BIT; k++) begin : g_bit
        logic [BW-1:0] tgt;
        logic          allowed;
        assign tgt      = (BW'(BIT_UNIT) * BW'(bit_half(k))) >> 1;
        assign allowed  = (k < NUM_BIT - 1) || (speed_i == SPD_SINGLE);
        assign b_hit[k] = ({4'b0000, bit_cnt_i} == tgt) && allowed;
    end

    always_comb begin
        code_o = PSC_DIV1;
        for (int k = NUM_PSC - 1; k >= 0; k--) begin
            if (m_hit[k]) begin
                code_o = 3'(k);
            end
        end
    end

    assign legal_o = spd_ok && (|m_hit) && (|b_hit);

endmodule

// File: rtl/slv_clk_ratio_mon.sv
module slv_clk_ratio_mon
    import scr_pkg::*;
#(
    parameter int unsigned CNT_W       = 12,
    parameter int unsigned SCNT_W      = 8,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned BASE_RATIO  = 256,
    parameter int unsigned BIT_UNIT    = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             lrck_i,
    input  logic             sclk_i,
    input  logic [1:0]       speed_i,
    output logic [2:0]       prescale_o,
    output logic [CNT_W-1:0] ratio_o,
    output logic             lock_o,
    output logic             err_o
);

    localparam int unsigned NUM_IN = 2;
    localparam int unsigned IDX_FRAME = 0;
    localparam int unsigned IDX_BIT   = 1;

    logic [NUM_IN-1:0] raw_in;
    logic [NUM_IN-1:0] rise;

    assign raw_in[IDX_FRAME] = lrck_i;
    assign raw_in[IDX_BIT]   = sclk_i;

    for (genvar i = 0; i < NUM_IN; i++) begin : g_sync
        scr_edge_sync #(
            .STAGES (SYNC_STAGES)
        ) u_sync (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .async_i (raw_in[i]),
            .rise_o  (rise[i])
        );
    end

    logic              meas_valid;
    logic [CNT_W-1:0]  meas_mclk;
    logic [SCNT_W-1:0] meas_bits;

    scr_period_meter #(
        .CNT_W  (CNT_W),
        .SCNT_W (SCNT_W)
    ) u_meter (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .frame_rise_i (rise[IDX_FRAME]),
        .bit_rise_i   (rise[IDX_BIT]),
        .meas_valid_o (meas_valid),
        .mclk_cnt_o   (meas_mclk),
        .bit_cnt_o    (meas_bits)
    );

    logic       legal;
    logic [2:0] judged_code;

    scr_ratio_judge #(
        .CNT_W      (CNT_W),
        .SCNT_W     (SCNT_W),
        .BASE_RATIO (BASE_RATIO),
        .BIT_UNIT   (BIT_UNIT)
    ) u_judge (
        .speed_i    (speed_i),
        .mclk_cnt_i (meas_mclk),
        .bit_cnt_i  (meas_bits),
        .legal_o    (legal),
        .code_o     (judged_code)
    );

    typedef struct packed {
        logic              locked;
        logic              err;
        logic [2:0]        code;
        logic [CNT_W-1:0]  ratio;
        logic              prev_ok;
        logic [CNT_W-1:0]  prev_m;
        logic [SCNT_W-1:0] prev_b;
        logic [1:0]        prev_spd;
    } trk_st_t;

    trk_st_t st_d, st_q;
    logic    repeat_match;

    assign repeat_match = st_q.prev_ok
                       && (st_q.prev_m == meas_mclk)
                       && (st_q.prev_b == meas_bits)
                       && (st_q.prev_spd == speed_i);

    always_comb begin
        st_d = st_q;
        if (meas_valid) begin
            st_d.ratio = meas_mclk;
            if (!legal) begin
                st_d.locked  = 1'b0;
                st_d.err     = 1'b1;
                st_d.prev_ok = 1'b0;
            end else begin
                if (repeat_match) begin
                    st_d.locked = 1'b1;
                    st_d.err    = 1'b0;
                    st_d.code   = judged_code;
                end else begin
                    st_d.locked = 1'b0;
                    st_d.err    = st_q.prev_ok;
                end
                st_d.prev_ok  = 1'b1;
                st_d.prev_m   = meas_mclk;
                st_d.prev_b   = meas_bits;
                st_d.prev_spd = speed_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign prescale_o = st_q.code;
    assign ratio_o    = st_q.ratio;
    assign lock_o     = st_q.locked;
    assign err_o      = st_q.err;

endmodule

// File: rtl/slv_clk_ratio_mon_chk.sv
module slv_clk_ratio_mon_chk #(
    parameter int unsigned CNT_W = 12
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [2:0]       prescale_o,
    input logic [CNT_W-1:0] ratio_o,
    input logic             lock_o,
    input logic             err_o
);

    AST_LOCK_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(lock_o && err_o)); // R12

    AST_CODE_ENCODED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        prescale_o <= 3'd4); // R3

    AST_CODE_HOLD_UNLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(prescale_o) |-> lock_o); // R10

    AST_LOCK_RATIO_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lock_o && $past(lock_o)) |-> $stable(ratio_o)); // R7

    AST_DROP_RAISES_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(lock_o) |-> err_o); // R9

endmodule

bind slv_clk_ratio_mon slv_clk_ratio_mon_chk #(
    .CNT_W (CNT_W)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .prescale_o (prescale_o),
    .ratio_o    (ratio_o),
    .lock_o     (lock_o),
    .err_o      (err_o)
);

// File: tb/slv_clk_ratio_mon_bench.sv
module slv_clk_ratio_mon_bench;

    localparam int CNT_W = 12;
    localparam int TMO   = 4095;

    logic             clk = 1'b0;
    logic             rst_ni;
    logic             lrck;
    logic             sclk;
    logic [1:0]       speed;
    logic [2:0]       prescale;
    logic [CNT_W-1:0] ratio;
    logic             lock;
    logic             err;

    always #10 clk = ~clk;

    slv_clk_ratio_mon u_slv_clk_ratio_mon (
        .clk_i      (clk),
        .rst_ni     (rst_ni),
        .lrck_i     (lrck),
        .sclk_i     (sclk),
        .speed_i    (speed),
        .prescale_o (prescale),
        .ratio_o    (ratio),
        .lock_o     (lock),
        .err_o      (err)
    );

    typedef struct {
        bit         lock;
        bit         err;
        logic [2:0] code;
        int         ratio;
        string      tag;
    } exp_t;

    exp_t sb_q[$];
    event rise_ev;
    int   checks   = 0;
    int   failures = 0;

    // reference model state, built from the requirements
    bit         m_started = 0;
    bit         m_prev_ok = 0;
    bit         m_lock    = 0;
    bit         m_err     = 0;
    logic [2:0] m_code    = 3'd0;
    int         m_ratio   = 0;
    int         m_prev_m, m_prev_s, m_prev_mode;
    int         m_last_m, m_last_s;

    function automatic void judge(input int mm, input int ss, input int mode,
                                  output bit ok, output logic [2:0] code);
        int base;
        int halves[5] = '{2, 3, 4, 6, 8};
        bit m_ok = 0;
        bit s_ok;
        code = 3'd0;
        if (mode == 3) begin
            ok = 0;
            return;
        end
        base = 256 >> mode;
        for (int k = 0; k < 5; k++) begin
            if (mm * 2 == base * halves[k]) begin
                m_ok = 1;
                code = 3'(k);
            end
        end
        s_ok = (ss == 32) || (ss == 48) || (ss == 64) || (ss == 128 && mode == 0);
        ok = m_ok && s_ok;
    endfunction

    function automatic void model_rise(input int mode, input int mm, input int ss, input string tag);
        exp_t       e;
        bit         ok;
        logic [2:0] code;
        if (m_started) begin
            judge(m_last_m, m_last_s, mode, ok, code);
            m_ratio = m_last_m;
            if (!ok) begin
                m_lock    = 0;
                m_err     = 1;
                m_prev_ok = 0;
            end else begin
                if (m_prev_ok && m_prev_m == m_last_m && m_prev_s == m_last_s && m_prev_mode == mode) begin
                    m_lock = 1;
                    m_err  = 0;
                    m_code = code;
                end else begin
                    m_lock = 0;
                    m_err  = m_prev_ok;
                end
                m_prev_ok   = 1;
                m_prev_m    = m_last_m;
                m_prev_s    = m_last_s;
                m_prev_mode = mode;
            end
        end
        m_started = 1;
        m_last_m  = mm;
        m_last_s  = ss;
        e.lock  = m_lock;
        e.err   = m_err;
        e.code  = m_code;
        e.ratio = m_ratio;
        e.tag   = tag;
        sb_q.push_back(e);
    endfunction

    task automatic compare(input exp_t e);
        checks++;
        if (lock !== e.lock || err !== e.err || prescale !== e.code || int'(ratio) != e.ratio) begin
            failures++;
            $display("FAIL %s: lock=%0d err=%0d code=%0d ratio=%0d, expected lock=%0d err=%0d code=%0d ratio=%0d",
                     e.tag, lock, err, prescale, ratio, e.lock, e.err, e.code, e.ratio);
        end
    endtask

    // driver: frames of mm master clocks carrying ss bit-clock periods
    task automatic drive_run(input int mode, input int mm, input int ss, input int nframes, input string tag);
        int d = mm / ss;
        for (int f = 0; f < nframes; f++) begin
            for (int c = 0; c < mm; c++) begin
                @(negedge clk);
                speed = 2'(mode);
                lrck  = (c < mm / 2);
                sclk  = ((c % d) >= d / 2);
                if (c == 0) begin
                    model_rise(mode, mm, ss, tag);
                    -> rise_ev;
                end
            end
        end
    endtask

    // monitor: outputs settle four master-clock edges after a driven frame edge (R2)
    initial begin
        forever begin
            @(rise_ev);
            repeat (4) @(posedge clk);
            @(negedge clk);
            if (sb_q.size() != 0) begin
                compare(sb_q.pop_front());
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: run still active, actual cycles=150000 expected fewer");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        exp_t e;
        rst_ni = 1'b0;
        lrck   = 1'b0;
        sclk   = 1'b0;
        speed  = 2'b00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        e.lock = 0; e.err = 0; e.code = 3'd0; e.ratio = 0; e.tag = "R1 reset";
        compare(e);
        rst_ni = 1'b1;
        @(negedge clk);
        e.tag = "R1 after reset";
        compare(e);

        drive_run(0, 256, 64, 4, "R3 R7 single 256");
        drive_run(0, 384, 48, 4, "R3 R9 single 384");
        drive_run(0, 1024, 128, 3, "R3 R6 single 1024/128");
        drive_run(0, 768, 48, 3, "R3 single 768");
        drive_run(0, 512, 64, 3, "R3 R10 single 512");
        drive_run(1, 192, 64, 4, "R4 R9 double 192 mode change");
        drive_run(1, 128, 32, 3, "R4 double 128");
        drive_run(1, 384, 48, 3, "R4 double 384");
        drive_run(1, 512, 64, 3, "R4 double 512");
        drive_run(1, 512, 128, 3, "R6 R8 R10 double bit 128");
        drive_run(2, 96, 32, 3, "R5 quad 96");
        drive_run(2, 64, 32, 3, "R5 quad 64");
        drive_run(2, 256, 64, 3, "R5 quad 256");
        drive_run(2, 128, 64, 3, "R5 quad 128");
        drive_run(2, 256, 128, 3, "R6 quad bit 128");
        drive_run(0, 320, 64, 3, "R8 single 320");
        drive_run(3, 256, 64, 3, "R6 reserved mode");
        drive_run(0, 256, 64, 3, "R2 R7 relock");

        // frame clock stops: expect the saturated timeout result (R11)
        repeat (4400) @(negedge clk);
        e.lock = 0; e.err = 1; e.code = m_code; e.ratio = TMO; e.tag = "R11 timeout";
        compare(e);
        m_started = 0;
        m_prev_ok = 0;
        m_lock    = 0;
        m_err     = 1;
        m_ratio   = TMO;
        drive_run(0, 256, 64, 3, "R11 restart");

        repeat (10) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule